// File: doc/BRIEF.md
# Dithered Sine Oscillator with Reduced-Width Output

This block is a numerically controlled sine oscillator whose output drives a converter narrower than its internal amplitude path. A phase accumulator advances by a programmable frequency word every clock. The upper bits of the phase index a constant-coded, full-period sine table that holds wide unsigned offset-binary samples.

Before each sample is cut down to the converter width, a pseudo-random value is added to it. That value spans exactly the range of the low-order bits that are about to be discarded. The periodic truncation error, which would otherwise produce discrete spurs, becomes broadband noise. Averaged over many clocks, the narrow output then tracks the wide sample at sub-LSB resolution. The adder clamps at the all-ones code, so a positive peak plus dither cannot wrap to the bottom of the range. A single enable turns the dither off, and the block then performs plain truncation.

With default parameters the accumulator is 16 bits, the table has 64 entries of 12 bits, the output is 8 bits and the dither spans 0 to 15.

Top module: `dithered_sine_nco`

## Requirements
- R1: On every clock edge with `rst_n` high, the phase register becomes (phase + `freq_word`) modulo 2^ACC_W. Its top TBL_AW bits form the table index.
- R2: Table entry i, with H = 2^(TBL_AW-1), p = i mod H, q = p*(H-p), MID = 2^(SMP_W-1) and AMP = MID-1, holds MID + floor(AMP*16*q / (5*H*H - 4*q)) for i < H and MID minus the same magnitude for i >= H.
- R3: With dither disabled, `dac_code` equals the table sample shifted right by SMP_W-DAC_W bits, which is plain truncation to its top DAC_W bits.
- R4: Latency is fixed. After the k-th clock edge following reset release (k >= 2), `dac_code` reflects the table entry for phase (k-2)*`freq_word` mod 2^ACC_W. After the first edge it is 0.
- R5: With dither enabled, the value added to the sample lies in 0 to 2^(SMP_W-DAC_W)-1. `dac_code` is therefore either the truncated sample or one code above it.
- R6: When the sample plus dither exceeds 2^SMP_W-1, the sum is clamped to all ones. `dac_code` is then 2^DAC_W-1 and never wraps toward zero.
- R7: With dither enabled and the phase held constant, the average of `dac_code` over many clocks equals the sample divided by 2^(SMP_W-DAC_W) within 0.06 code.
- R8: While `rst_n` is low at a clock edge, the phase clears to 0, the pipeline clears, and `dac_code` reads 0 after that edge.
- R9: The `dither_en` input is sampled together with the table read. A change on it reaches `dac_code` two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_word | input | ACC_W | Phase increment per clock |
| dither_en | input | 1 | 1 adds random dither before truncation |
| dac_code | output | DAC_W | Unsigned offset-binary converter sample |

## Verification
Free-running sweeps use several frequency words, with dither off, and compare every output sample against the closed-form table and the two-clock phase-to-output latency. These include a unit step, fractional steps, a word that wraps the accumulator backwards, half-period and zero steps. A sweep like this separates accumulator, indexing and latency faults from table faults. The phase is then held at a fixed index. An entry with a nonzero discarded fraction shows whether the dither has the right span and an unbiased mean. The positive peak entry shows whether the clamp works, because a wrapping adder would produce zero codes there. Resets in mid-run and toggles of the dither enable check the cleared state and the timing of the enable.

// File: rtl/nco_pkg.sv
// Package: shared sizing defaults and the closed-form sine code used to
// build the constant table. Assumes SMP_W <= 30 so that products fit in longint.
package nco_pkg;

    localparam int DEF_ACC_W  = 16;
    localparam int DEF_TBL_AW = 6;
    localparam int DEF_SMP_W  = 12;
    localparam int DEF_DAC_W  = 8;

    // Rational sine approximation over a half period, mirrored for the second half.
    function automatic longint sine_code(input int idx, input int aw, input int sw);
        longint half, p, q, mid, amp, mag;
        half = longint'(1) << (aw - 1);
        p    = longint'(idx) % half;
        q    = p * (half - p);
        mid  = longint'(1) << (sw - 1);
        amp  = mid - 1;
        mag  = (amp * 16 * q) / (5 * half * half - 4 * q);
        return (longint'(idx) < half) ? mid + mag : mid - mag;
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
// Phase accumulator: adds the frequency word each clock, modulo 2^ACC_W.
// Assumes synchronous active-low reset; the sum wraps naturally.
module nco_phase_acc #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] phase
);

    // Advance phase by step, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + step;
    end

endmodule

// File: rtl/nco_sine_rom.sv
// Sine table: one full period of 2^TBL_AW unsigned offset-binary samples,
// built from constants at elaboration; registered read (one clock).
module nco_sine_rom #(
    parameter int TBL_AW = 6,
    parameter int SMP_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TBL_AW-1:0] addr,
    output logic [SMP_W-1:0]  sample
);

    localparam int DEPTH = 1 << TBL_AW;

    logic [SMP_W-1:0] table_w [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam logic [SMP_W-1:0] CODE = SMP_W'(nco_pkg::sine_code(i, TBL_AW, SMP_W));
        assign table_w[i] = CODE;
    end

    // Registered table lookup, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sample <= '0;
        else        sample <= table_w[addr];
    end

endmodule

// File: rtl/nco_dither_gen.sv
// Dither source: free-running Galois LFSR whose low DTH_W bits give a value
// uniform over 0..2^DTH_W-1. Output is registered and forced to 0 when disabled.
// Assumes LFSR_W >= DTH_W and a maximal-length tap mask.
module nco_dither_gen #(
    parameter int              DTH_W  = 4,
    parameter int              LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    output logic [DTH_W-1:0] dither
);

    logic [LFSR_W-1:0] state;
    logic [LFSR_W-1:0] state_nx;

    // Next LFSR state: shift right, fold taps in when the bit shifted out is set.
    always_comb begin
        state_nx = state >> 1;
        if (state[0]) state_nx = state_nx ^ TAPS;
    end

    // Step the generator every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEED;
        else        state <= state_nx;
    end

    // Register the gated dither value, aligned with the table read.
    always_ff @(posedge clk) begin
        if (!rst_n)      dither <= '0;
        else if (enable) dither <= state[DTH_W-1:0];
        else             dither <= '0;
    end

endmodule

// File: rtl/nco_trunc_sat.sv
// Dither adder with clamp at all ones, then truncation to the top DAC_W bits.
// Registered output. Assumes DAC_W < SMP_W.
module nco_trunc_sat #(
    parameter int SMP_W = 12,
    parameter int DAC_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SMP_W-1:0]       sample,
    input  logic [SMP_W-DAC_W-1:0] dither,
    output logic [DAC_W-1:0]       code
);

    localparam int DTH_W = SMP_W - DAC_W;

    logic [SMP_W:0]   sum;
    logic [SMP_W-1:0] clamped;

    // Widened add, clamp when the carry out is set.
    always_comb begin
        sum     = {1'b0, sample} + {{(DAC_W + 1){1'b0}}, dither};
        clamped = sum[SMP_W] ? '1 : sum[SMP_W-1:0];
    end

    // Keep the top DAC_W bits of the clamped sum.
    always_ff @(posedge clk) begin
        if (!rst_n) code <= '0;
        else        code <= clamped[SMP_W-1 -: DAC_W];
    end

endmodule

// File: rtl/dithered_sine_nco.sv
// Top: phase accumulator -> sine table (+ dither, same stage) -> clamp/truncate.
// Three register stages; phase-to-output latency is two clocks, frequency word
// to output three. Assumes DAC_W < SMP_W and TBL_AW <= ACC_W.
module dithered_sine_nco #(
    parameter int ACC_W  = nco_pkg::DEF_ACC_W,
    parameter int TBL_AW = nco_pkg::DEF_TBL_AW,
    parameter int SMP_W  = nco_pkg::DEF_SMP_W,
    parameter int DAC_W  = nco_pkg::DEF_DAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] freq_word,
    input  logic             dither_en,
    output logic [DAC_W-1:0] dac_code
);

    localparam int DTH_W = SMP_W - DAC_W;

    logic [ACC_W-1:0] phase_q;
    logic [SMP_W-1:0] sample_q;
    logic [DTH_W-1:0] dither_q;

    nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (freq_word),
        .phase (phase_q)
    );

    nco_sine_rom #(.TBL_AW(TBL_AW), .SMP_W(SMP_W)) u_rom (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (phase_q[ACC_W-1 -: TBL_AW]),
        .sample (sample_q)
    );

    nco_dither_gen #(.DTH_W(DTH_W)) u_dth (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (dither_en),
        .dither (dither_q)
    );

    nco_trunc_sat #(.SMP_W(SMP_W), .DAC_W(DAC_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (sample_q),
        .dither (dither_q),
        .code   (dac_code)
    );

endmodule

// File: rtl/dithered_sine_nco_chk.sv
// Checker: timing properties across the pipeline stages of the oscillator.
module dithered_sine_nco_chk #(
    parameter int ACC_W  = 16,
    parameter int SMP_W  = 12,
    parameter int DAC_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ACC_W-1:0] freq_word,
    input logic [ACC_W-1:0] phase_q,
    input logic [SMP_W-1:0] sample_q,
    input logic [SMP_W-DAC_W-1:0] dither_q,
    input logic [DAC_W-1:0] dac_code
);

    localparam int SH = SMP_W - DAC_W;
    localparam logic [DAC_W-1:0] TOP = '1;

    // R1
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> phase_q == ACC_W'($past(phase_q) + $past(freq_word)));

    // R3
    plain_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dither_q) == '0) |-> dac_code == DAC_W'($past(sample_q) >> SH));

    // R5
    dither_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && DAC_W'($past(sample_q) >> SH) != TOP) |->
        (dac_code - DAC_W'($past(sample_q) >> SH)) <= DAC_W'(1));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ({1'b0, $past(sample_q)} + (SMP_W + 1)'($past(dither_q))) > (SMP_W + 1)'({SMP_W{1'b1}}))
        |-> dac_code == TOP);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> dac_code == '0);

endmodule

bind dithered_sine_nco dithered_sine_nco_chk #(
    .ACC_W(ACC_W), .SMP_W(SMP_W), .DAC_W(DAC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .freq_word (freq_word),
    .phase_q   (phase_q),
    .sample_q  (sample_q),
    .dither_q  (dither_q),
    .dac_code  (dac_code)
);

// File: tb/dithered_sine_nco_test.sv
`timescale 1ns/1ps
module dithered_sine_nco_test;

    localparam int ACC_W = 16;
    localparam int TBL_AW = 6;
    localparam int SMP_W = 12;
    localparam int DAC_W = 8;
    localparam int SH = SMP_W - DAC_W;
    localparam int NVEC = 8;
    localparam int VK [NVEC] = '{1024, 512, 3000, 65535, 32768, 21845, 0, 1234};
    localparam int VN [NVEC] = '{70, 40, 60, 70, 12, 30, 8, 80};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ACC_W-1:0] freq_word = '0;
    logic dither_en = 1'b0;
    logic [DAC_W-1:0] dac_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dithered_sine_nco #(.ACC_W(ACC_W), .TBL_AW(TBL_AW), .SMP_W(SMP_W), .DAC_W(DAC_W)) uut (
        .clk(clk), .rst_n(rst_n), .freq_word(freq_word),
        .dither_en(dither_en), .dac_code(dac_code)
    );

    // Table entry from the R2 formula.
    function automatic int ref_sample(input int idx);
        longint h, p, q, mid, amp, mag;
        h = 1 << (TBL_AW - 1);
        p = idx % h;
        q = p * (h - p);
        mid = 1 << (SMP_W - 1);
        amp = mid - 1;
        mag = (amp * 16 * q) / (5 * h * h - 4 * q);
        return int'((idx < h) ? mid + mag : mid - mag);
    endfunction

    function automatic int idx_of(input longint ph);
        return int'((ph % (1 << ACC_W)) >> (ACC_W - TBL_AW));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reset, then release with the given word and dither setting (at the falling edge).
    task automatic restart(input int k, input bit en);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        freq_word = ACC_W'(k);
        dither_en = en;
        rst_n = 1'b1;
    endtask

    // Move phase to a table index and hold it there; wait until output follows.
    task automatic hold_index(input int idx, input bit en);
        restart(idx << (ACC_W - TBL_AW), en);
        @(negedge clk);
        freq_word = '0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int s;
        int lo;
        int hits;
        int cnt;
        bit bad;
        // R8: output clear while held in reset
        repeat (3) @(negedge clk);
        check("R8 reset output", int'(dac_code), 0);

        // R1 R2 R3 R4: free-running sweeps, dither off
        for (int v = 0; v < NVEC; v++) begin
            restart(VK[v], 1'b0);
            for (int e = 1; e <= VN[v]; e++) begin
                @(negedge clk);
                if (e == 1) check("R4 first edge", int'(dac_code), 0);
                else check("R1 R2 R3 R4 sweep", int'(dac_code),
                           ref_sample(idx_of(longint'(e - 2) * VK[v])) >> SH);
            end
        end

        // R5 R7: held index with nonzero discarded fraction
        s = ref_sample(5);
        lo = s >> SH;
        hold_index(5, 1'b0);
        check("R3 held plain", int'(dac_code), lo);
        hold_index(5, 1'b1);
        hits = 0; cnt = 0; bad = 1'b0;
        for (int n = 0; n < 8192; n++) begin
            @(negedge clk);
            if (dac_code == DAC_W'(lo + 1)) hits++;
            else if (dac_code != DAC_W'(lo)) bad = 1'b1;
            cnt++;
        end
        check("R5 dither span", int'(bad), 0);
        check("R5 dither active", int'(hits > 0), 1);
        begin
            real meas, want;
            meas = real'(hits) / real'(cnt);
            want = real'(s % (1 << SH)) / real'(1 << SH);
            check("R7 mean", int'(meas > want - 0.06 && meas < want + 0.06), 1);
            if (meas <= want - 0.06 || meas >= want + 0.06)
                $display("  mean fraction measured %f wanted %f", meas, want);
        end

        // R9: disable dither, output returns to truncation after two edges
        @(negedge clk);
        dither_en = 1'b0;
        repeat (2) @(negedge clk);
        bad = 1'b0;
        for (int n = 0; n < 64; n++) begin
            if (dac_code != DAC_W'(lo)) bad = 1'b1;
            @(negedge clk);
        end
        check("R9 enable off latency", int'(bad), 0);

        // R6: positive peak with dither never wraps
        hold_index(1 << (TBL_AW - 2), 1'b1);
        check("R2 peak entry", ref_sample(1 << (TBL_AW - 2)), (1 << SMP_W) - 1);
        bad = 1'b0;
        for (int n = 0; n < 512; n++) begin
            @(negedge clk);
            if (dac_code != '1) bad = 1'b1;
        end
        check("R6 clamp at peak", int'(bad), 0);

        // R3: trough entry, dither off
        hold_index(3 << (TBL_AW - 2), 1'b0);
        check("R3 trough", int'(dac_code), ref_sample(3 << (TBL_AW - 2)) >> SH);

        // R8: reset in mid-run clears output after one edge
        restart(1024, 1'b1);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 mid-run reset", int'(dac_code), 0);
        // R4: after release the phase restarts at zero
        freq_word = ACC_W'(1024);
        dither_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R4 restart from zero", int'(dac_code), ref_sample(0) >> SH);
        @(negedge clk);
        check("R4 restart step", int'(dac_code), ref_sample(1) >> SH);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule